// File: doc/BRIEF.md
# Queue Doorbell Decoder and Pointer Tracker

This block sits behind the register window of a host-driven command engine and turns doorbell writes into queue pointer updates. Writes that land at or above a base offset (0x1000 by default) are split into interleaved 4-byte slots. Each 8-byte pair belongs to one queue index: the lower slot carries a new submission queue tail, the upper slot a new completion queue head. The block keeps, per queue index, a valid flag, a size and the live pointers of both rings. A separate configuration port creates and deletes queues. A third input lets the completion poster advance a completion ring's tail, so that the block always knows when a ring is full.

From each accepted write the block raises single-cycle requests for the engines around it. A tail update on a submission queue raises a work pulse for that queue. A head update that frees a slot in a completion ring which was full raises a restart pulse for that ring, and a work pulse for every submission queue bound to it. A head update that leaves entries still unread raises an interrupt request tagged with the ring index. Bad writes are dropped silently: unaligned addresses, indices out of range, queues that do not exist and pointers at or beyond the ring size. The write port is a plain strobe and is never back-pressured; every request output is a registered pulse.

Top module: `dbell_tracker`

## Requirements
- R1: A write whose address has either of bits [1:0] set changes no pointer and raises no pulse.
- R2: A write below the window base, or whose queue index ((address − base) >> 3) is not below NUM_Q, changes nothing and raises no pulse.
- R3: Bit 2 of (address − base) selects the target: 0 updates the submission tail of the indexed queue, 1 updates the completion head of the indexed queue.
- R4: Only wr_data[15:0] is taken as the new pointer; the upper data bits are ignored.
- R5: A write aimed at a queue that is not valid (never created, or deleted) changes nothing and raises no pulse.
- R6: A write whose pointer value is not less than the queue's size changes nothing and raises no pulse.
- R7: An accepted submission tail write stores the tail, which shows on sq_tail bits [q*16 +: 16], and pulses sq_kick[q] in the cycle after the write.
- R8: An accepted head write to a completion ring that was full before the write (that is, (tail+1) mod size equals the old head) pulses cq_wake[c], together with sq_kick for every valid submission queue bound to c, in the cycle after the write.
- R9: An accepted head write pulses irq_valid with irq_cqid = c in the cycle after the write if and only if the ring's tail differs from the new head.
- R10: A cpl_post to a valid ring that is not full advances its tail by one, wrapping from size−1 to 0; a post to a full or invalid ring is dropped.
- R11: A configuration create (cfg_create=1) makes the queue valid with the given size and both of its pointers at zero, and for a submission queue records the bound ring cfg_bind; a delete (cfg_create=0) makes the queue invalid. cfg_is_cq=1 targets the completion ring, 0 targets the submission queue.
- R12: After reset no queue is valid, every tail reads zero and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data; the low PTR_W bits are the pointer |
| cfg_valid | input | 1 | Queue configuration strobe |
| cfg_is_cq | input | 1 | 1 = completion ring, 0 = submission queue |
| cfg_create | input | 1 | 1 = create, 0 = delete |
| cfg_qid | input | QID_W | Queue index being configured |
| cfg_size | input | PTR_W | Number of entries for a create |
| cfg_bind | input | QID_W | Completion ring bound to a created submission queue |
| cpl_post | input | 1 | Completion poster has written one entry |
| cpl_cqid | input | QID_W | Ring the entry went to |
| sq_kick | output | NUM_Q | Per-submission-queue work pulse |
| cq_wake | output | NUM_Q | Per-ring restart pulse after a full ring drained |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_cqid | output | QID_W | Ring that the interrupt request belongs to |
| sq_tail | output | NUM_Q*PTR_W | Current tail of every submission queue |

## Verification
Every pulse (sq_kick, cq_wake, irq_valid with irq_cqid) comes from an output register. Each is due exactly one cycle after the write that caused it. A stored tail shows on sq_tail after the same single clock edge. A ring's full state changes one edge after a post or a head write, and it first affects an output on the next head write. The bench applies at most one operation per cycle and drives it on a falling edge. It compares every output on the following falling edge, one rising edge later. It then clears the strobes, so each comparison belongs to exactly one operation.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  // Slot type selected by bit 2 of the window offset.
  typedef enum logic {
    DB_SQ_TAIL = 1'b0,
    DB_CQ_HEAD = 1'b1
  } db_kind_e;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_Q  = 64,
  parameter int QID_W  = 6,
  parameter logic [ADDR_W-1:0] DB_BASE = 'h1000
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              hit,
  output db_kind_e          kind,
  output logic [QID_W-1:0]  qid
);
  localparam int IDX_W = ADDR_W - 3;
  localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(NUM_Q);

  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;
  logic              in_win, aligned, in_range;

  always_comb begin
    off      = wr_addr - DB_BASE;
    idx      = off[ADDR_W-1:3];
    in_win   = (wr_addr >= DB_BASE);
    aligned  = (off[1:0] == 2'b00);
    in_range = (idx < IDX_LIM);
    hit      = wr_valid && in_win && aligned && in_range;
    kind     = db_kind_e'(off[2]);
    qid      = idx[QID_W-1:0];
  end
endmodule

// File: rtl/dbell_sq_slot.sv
module dbell_sq_slot #(
  parameter int PTR_W = 16,
  parameter int QID_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             create,
  input  logic             remove,
  input  logic [PTR_W-1:0] new_size,
  input  logic [QID_W-1:0] new_bind,
  input  logic             tl_wr,
  input  logic [PTR_W-1:0] tl_val,
  output logic             valid,
  output logic [PTR_W-1:0] tail,
  output logic [QID_W-1:0] bind_cq,
  output logic             tl_ok
);
  logic [PTR_W-1:0] size;

  assign tl_ok = valid && (tl_val < size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      size    <= '0;
      tail    <= '0;
      bind_cq <= '0;
    end else begin
      if (tl_wr && tl_ok) tail <= tl_val;
      if (create) begin
        valid   <= 1'b1;
        size    <= new_size;
        tail    <= '0;
        bind_cq <= new_bind;
      end else if (remove) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbell_cq_ring.sv
module dbell_cq_ring #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             create,
  input  logic             remove,
  input  logic [PTR_W-1:0] new_size,
  input  logic             hd_wr,
  input  logic [PTR_W-1:0] hd_val,
  input  logic             post,
  output logic             valid,
  output logic             full,
  output logic             hd_ok,
  output logic [PTR_W-1:0] tail
);
  logic [PTR_W-1:0] size, head, tail_nxt;
  logic [PTR_W:0]   tail_inc;

  always_comb begin
    tail_inc = {1'b0, tail} + 1'b1;
    tail_nxt = (tail_inc == {1'b0, size}) ? '0 : tail_inc[PTR_W-1:0];
    // full is taken from the head held before any update this cycle
    full     = valid && (tail_nxt == head);
    hd_ok    = valid && (hd_val < size);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      size  <= '0;
      head  <= '0;
      tail  <= '0;
    end else begin
      if (hd_wr && hd_ok) head <= hd_val;
      if (post && valid && !full) tail <= tail_nxt;
      if (create) begin
        valid <= 1'b1;
        size  <= new_size;
        head  <= '0;
        tail  <= '0;
      end else if (remove) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbell_tracker.sv
module dbell_tracker
  import dbell_pkg::*;
#(
  parameter int NUM_Q  = 64,
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] DB_BASE = 'h1000,
  localparam int QID_W = $clog2(NUM_Q)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   cfg_valid,
  input  logic                   cfg_is_cq,
  input  logic                   cfg_create,
  input  logic [QID_W-1:0]       cfg_qid,
  input  logic [PTR_W-1:0]       cfg_size,
  input  logic [QID_W-1:0]       cfg_bind,
  input  logic                   cpl_post,
  input  logic [QID_W-1:0]       cpl_cqid,
  output logic [NUM_Q-1:0]       sq_kick,
  output logic [NUM_Q-1:0]       cq_wake,
  output logic                   irq_valid,
  output logic [QID_W-1:0]       irq_cqid,
  output logic [NUM_Q*PTR_W-1:0] sq_tail
);
  logic             db_hit;
  db_kind_e         db_kind;
  logic [QID_W-1:0] db_qid;
  logic [PTR_W-1:0] db_ptr;
  logic             unused_hi;

  assign db_ptr    = wr_data[PTR_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:PTR_W];

  dbell_decode #(
    .ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .QID_W(QID_W), .DB_BASE(DB_BASE)
  ) u_dec (
    .wr_valid(wr_valid), .wr_addr(wr_addr),
    .hit(db_hit), .kind(db_kind), .qid(db_qid)
  );

  logic [NUM_Q-1:0] sq_v, sq_ok, cq_v, cq_ok, cq_full;
  logic [QID_W-1:0] sq_bind [NUM_Q];
  logic [PTR_W-1:0] cq_tail [NUM_Q];

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    localparam logic [QID_W-1:0] QI = QID_W'(q);
    logic sel_cfg;
    assign sel_cfg = cfg_valid && (cfg_qid == QI);

    dbell_sq_slot #(.PTR_W(PTR_W), .QID_W(QID_W)) u_sq (
      .clk(clk), .rst_n(rst_n),
      .create(sel_cfg && !cfg_is_cq && cfg_create),
      .remove(sel_cfg && !cfg_is_cq && !cfg_create),
      .new_size(cfg_size), .new_bind(cfg_bind),
      .tl_wr(db_hit && (db_kind == DB_SQ_TAIL) && (db_qid == QI)),
      .tl_val(db_ptr),
      .valid(sq_v[q]), .tail(sq_tail[q*PTR_W +: PTR_W]),
      .bind_cq(sq_bind[q]), .tl_ok(sq_ok[q])
    );

    dbell_cq_ring #(.PTR_W(PTR_W)) u_cq (
      .clk(clk), .rst_n(rst_n),
      .create(sel_cfg && cfg_is_cq && cfg_create),
      .remove(sel_cfg && cfg_is_cq && !cfg_create),
      .new_size(cfg_size),
      .hd_wr(db_hit && (db_kind == DB_CQ_HEAD) && (db_qid == QI)),
      .hd_val(db_ptr),
      .post(cpl_post && (cpl_cqid == QI)),
      .valid(cq_v[q]), .full(cq_full[q]), .hd_ok(cq_ok[q]),
      .tail(cq_tail[q])
    );
  end

  logic             sq_acc, cq_acc, wake_any;
  logic [NUM_Q-1:0] kick_nxt, wake_nxt;
  logic             irq_nxt;
  logic             unused_cqv;

  assign unused_cqv = ^cq_v;

  always_comb begin
    sq_acc   = db_hit && (db_kind == DB_SQ_TAIL) && sq_ok[db_qid];
    cq_acc   = db_hit && (db_kind == DB_CQ_HEAD) && cq_ok[db_qid];
    wake_any = cq_acc && cq_full[db_qid];
    irq_nxt  = cq_acc && (cq_tail[db_qid] != db_ptr);
    kick_nxt = '0;
    wake_nxt = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (sq_acc && (db_qid == QID_W'(q))) kick_nxt[q] = 1'b1;
      if (wake_any && sq_v[q] && (sq_bind[q] == db_qid)) kick_nxt[q] = 1'b1;
      if (wake_any && (db_qid == QID_W'(q))) wake_nxt[q] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_kick   <= '0;
      cq_wake   <= '0;
      irq_valid <= 1'b0;
      irq_cqid  <= '0;
    end else begin
      sq_kick   <= kick_nxt;
      cq_wake   <= wake_nxt;
      irq_valid <= irq_nxt;
      irq_cqid  <= db_qid;
    end
  end
endmodule

// File: rtl/dbell_tracker_checks.sv
module dbell_tracker_checks #(
  parameter int NUM_Q  = 64,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DB_BASE = 'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [NUM_Q-1:0]  sq_kick,
  input logic [NUM_Q-1:0]  cq_wake,
  input logic              irq_valid
);
  p_unaligned_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_addr[1:0] != 2'b00)) |=> (sq_kick == '0 && cq_wake == '0 && !irq_valid));

  p_below_window_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_addr < DB_BASE)) |=> (sq_kick == '0 && cq_wake == '0 && !irq_valid));

  p_kick_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|sq_kick) |-> $past(wr_valid));

  p_single_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cq_wake));

  p_wake_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|cq_wake) |-> $past(wr_valid));

  p_irq_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(wr_valid));
endmodule

bind dbell_tracker dbell_tracker_checks #(
  .NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .DB_BASE(DB_BASE)
) u_checks (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .sq_kick(sq_kick), .cq_wake(cq_wake), .irq_valid(irq_valid)
);

// File: tb/dbell_tracker_bench.sv
module dbell_tracker_bench;
  localparam int NQ = 64;
  localparam int PW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic [15:0]       wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic              cfg_valid = 1'b0, cfg_is_cq = 1'b0, cfg_create = 1'b0;
  logic [5:0]        cfg_qid = '0, cfg_bind = '0, cpl_cqid = '0;
  logic [15:0]       cfg_size = '0;
  logic              cpl_post = 1'b0;
  logic [NQ-1:0]     sq_kick, cq_wake;
  logic              irq_valid;
  logic [5:0]        irq_cqid;
  logic [NQ*PW-1:0]  sq_tail;

  always #5 clk = ~clk;

  dbell_tracker u_dbell_tracker (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_valid(cfg_valid), .cfg_is_cq(cfg_is_cq),
    .cfg_create(cfg_create), .cfg_qid(cfg_qid), .cfg_size(cfg_size),
    .cfg_bind(cfg_bind), .cpl_post(cpl_post), .cpl_cqid(cpl_cqid),
    .sq_kick(sq_kick), .cq_wake(cq_wake), .irq_valid(irq_valid),
    .irq_cqid(irq_cqid), .sq_tail(sq_tail)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // independent model state
  bit m_sqv [NQ];
  int m_sqsz[NQ], m_sqt[NQ], m_sqcq[NQ];
  bit m_cqv [NQ];
  int m_cqsz[NQ], m_cqh[NQ], m_cqt[NQ];

  logic [NQ-1:0] e_kick, e_wake;
  logic          e_irq;
  logic [5:0]    e_irqid;

  function automatic bit ring_full(int c);
    return m_cqv[c] && (((m_cqt[c] + 1) % m_cqsz[c]) == m_cqh[c]);
  endfunction

  function automatic logic [NQ*PW-1:0] exp_tails();
    logic [NQ*PW-1:0] v;
    for (int q = 0; q < NQ; q++) v[q*PW +: PW] = m_sqt[q][15:0];
    return v;
  endfunction

  task automatic clear_exp();
    e_kick = '0; e_wake = '0; e_irq = 1'b0; e_irqid = '0;
  endtask

  task automatic check(string tag);
    bit ok;
    ok = (sq_kick == e_kick) && (cq_wake == e_wake) && (irq_valid == e_irq) &&
         (!e_irq || irq_cqid == e_irqid) && (sq_tail == exp_tails());
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: kick=%h wake=%h irq=%b id=%0d | expected kick=%h wake=%h irq=%b id=%0d (tails match=%b)",
               tag, sq_kick, cq_wake, irq_valid, irq_cqid, e_kick, e_wake, e_irq, e_irqid,
               sq_tail == exp_tails());
    end
  endtask

  task automatic finish_op(string tag);
    @(negedge clk);
    check(tag);
    wr_valid = 1'b0; cfg_valid = 1'b0; cpl_post = 1'b0;
  endtask

  task automatic do_db(logic [15:0] a, logic [31:0] d, string tag);
    int off, q, p;
    clear_exp();
    if (a >= 16'h1000 && a[1:0] == 2'b00) begin
      off = int'(a) - 'h1000;
      q = off >> 3;
      p = int'(d[15:0]);
      if (q < NQ) begin
        if (off[2] == 1'b0) begin
          if (m_sqv[q] && p < m_sqsz[q]) begin m_sqt[q] = p; e_kick[q] = 1'b1; end
        end else if (m_cqv[q] && p < m_cqsz[q]) begin
          if (ring_full(q)) begin
            e_wake[q] = 1'b1;
            for (int j = 0; j < NQ; j++) if (m_sqv[j] && m_sqcq[j] == q) e_kick[j] = 1'b1;
          end
          e_irq = (m_cqt[q] != p);
          e_irqid = 6'(q);
          m_cqh[q] = p;
        end
      end
    end
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    finish_op(tag);
  endtask

  task automatic do_cfg(bit is_cq, bit create, int q, int sz, int bnd, string tag);
    clear_exp();
    if (is_cq) begin
      if (create) begin m_cqv[q] = 1; m_cqsz[q] = sz; m_cqh[q] = 0; m_cqt[q] = 0; end
      else m_cqv[q] = 0;
    end else begin
      if (create) begin m_sqv[q] = 1; m_sqsz[q] = sz; m_sqt[q] = 0; m_sqcq[q] = bnd; end
      else m_sqv[q] = 0;
    end
    cfg_valid = 1'b1; cfg_is_cq = is_cq; cfg_create = create;
    cfg_qid = 6'(q); cfg_size = 16'(sz); cfg_bind = 6'(bnd);
    finish_op(tag);
  endtask

  task automatic do_post(int c, string tag);
    clear_exp();
    if (m_cqv[c] && !ring_full(c)) m_cqt[c] = (m_cqt[c] + 1) % m_cqsz[c];
    cpl_post = 1'b1; cpl_cqid = 6'(c);
    finish_op(tag);
  endtask

  function automatic logic [15:0] sq_addr(int q);
    return 16'(32'h1000 + q * 8);
  endfunction
  function automatic logic [15:0] cq_addr(int q);
    return 16'(32'h1004 + q * 8);
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0d1b;
    void'($urandom(seed));
    for (int q = 0; q < NQ; q++) begin
      m_sqv[q] = 0; m_sqsz[q] = 0; m_sqt[q] = 0; m_sqcq[q] = 0;
      m_cqv[q] = 0; m_cqsz[q] = 0; m_cqh[q] = 0; m_cqt[q] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_exp();
    check("R12 reset state");

    do_db(sq_addr(0), 32'h0000_0001, "R5 write to missing queue");
    do_cfg(1, 1, 1, 4, 0, "R11 create ring 1");
    do_cfg(0, 1, 0, 8, 1, "R11 create sq 0");
    do_cfg(0, 1, 2, 4, 1, "R11 create sq 2");
    do_db(sq_addr(0), 32'hABCD_0005, "R4 R7 tail from low bits");
    do_db(sq_addr(0), 32'h0000_0008, "R6 tail equal to size");
    do_db(16'h1001, 32'h0000_0002, "R1 unaligned write");
    do_db(16'h1002, 32'h0000_0002, "R1 unaligned write");
    do_db(16'h0FF8, 32'h0000_0002, "R2 below window");
    do_db(sq_addr(64), 32'h0000_0002, "R2 index out of range");
    do_post(1, "R10 post");
    do_post(1, "R10 post");
    do_post(1, "R10 post to full");
    do_post(1, "R10 post dropped when full");
    do_db(cq_addr(1), 32'h0000_0004, "R6 head equal to size");
    do_db(cq_addr(1), 32'h0000_0002, "R3 R8 R9 full ring drains");
    do_db(cq_addr(1), 32'h0000_0003, "R9 head catches tail");
    do_db(sq_addr(2), 32'h0000_0003, "R3 R7 sq 2 tail");
    do_cfg(0, 0, 2, 0, 0, "R11 delete sq 2");
    do_db(sq_addr(2), 32'h0000_0001, "R5 R11 write to deleted queue");

    for (int i = 0; i < 3000; i++) begin
      int r, q, a;
      r = int'($urandom % 100);
      q = int'($urandom % 10);
      if (r < 8) begin
        do_cfg(($urandom % 2) == 1, ($urandom % 5) != 0, q % 8, 2 + int'($urandom % 5),
               int'($urandom % 8), "R11 random config");
      end else if (r < 38) begin
        do_post(q, "R10 random post");
      end else begin
        int p;
        logic [31:0] d;
        p = int'($urandom % 9);
        d = {16'($urandom), 16'(p)};
        a = ($urandom % 2 == 0) ? int'(sq_addr(q)) : int'(cq_addr(q));
        case ($urandom % 12)
          0: a = a + 1 + int'($urandom % 3);
          1: a = 'h0800 + int'($urandom % 'h800);
          2: a = int'(sq_addr(64 + int'($urandom % 20)));
          default: ;
        endcase
        do_db(16'(a), d, (a[2] == 1'b1) ? "R8 R9 random head write" : "R7 random tail write");
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule